// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block gathers interrupt requests from four sources: an external input pin, the overflow of timer 0, the overflow of timer 1 and the end of an analogue-to-digital conversion. Each source has a sticky request flag. A flag is set by a hardware event and stays set until the source is serviced or software clears it. The external pin is watched by an edge detector. A two-bit selector picks rising, falling or both edges, or turns the pin off.

A processor core gives the block an instruction-phase strobe. On a strobe cycle the controller looks at every flag. A flag can be serviced only when its own enable and the global enable are both set and the return stack has room. If several flags qualify, the one with the highest fixed priority wins. The block then raises a one-cycle call request together with that source's vector address. After that it waits for the core's acknowledge. On the acknowledge it clears the serviced flag and the global enable, so that no further interrupt can be serviced until software turns the global enable on again. A wake output follows any pending flag, so that each source can bring the processor out of power-down.

A build parameter selects one or two timers. With a single timer the timer-1 source is absent and the conversion vector moves down one slot.

Top module: `irq_vector_ctrl`

## Requirements
- R1: When several sources qualify at the same strobe, the external pin wins first, then timer 0, then timer 1, then the converter.
- R2: The vectors are 0x04 for the external pin, 0x08 for timer 0, 0x0C for timer 1 and 0x10 for the converter. Every bus of four bits (enables, clears, flags) uses bit 0 for the external pin, bit 1 for timer 0, bit 2 for timer 1 and bit 3 for the converter.
- R3: A source is serviced only when its flag, its enable and the global enable are all set and `stack_full` is low.
- R4: Requests are evaluated only on a cycle where `phase_stb` is high. `call_req` is raised in the cycle after that strobe. A request that arrives between strobes is taken at the next strobe.
- R5: When `call_ack` arrives while a call is outstanding, the serviced flag and the global enable are cleared in the next cycle.
- R6: A flag stays set while its enable is off. A flag is cleared only by servicing or by a `flag_clr` bit.
- R7: A hardware set event wins over a clear of the same flag in the same cycle, whether that clear comes from software or from an acknowledge.
- R8: `wake` is high whenever any flag is set, regardless of the enables.
- R9: `edge_sel` encoding: 00 turns the pin off, 01 selects rising edges, 10 selects falling edges, 11 selects both edges.
- R10: `call_req` lasts exactly one cycle. No new call is raised until the acknowledge has been taken.
- R11: With `NUM_TIMERS`=1 the timer-1 flag never sets and the converter vector is 0x0C.
- R12: After reset all flags, all enables, the global enable and `call_req` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_stb | input | 1 | Instruction-phase strobe; evaluation happens only on cycles where it is high |
| ext_pin | input | 1 | External interrupt pin, already synchronous to `clk` |
| edge_sel | input | 2 | Edge selection for the pin |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| adc_done | input | 1 | Conversion-complete pulse |
| stack_full | input | 1 | High when the return stack has no room |
| cfg_wr | input | 1 | Loads the global enable and the per-source enables |
| cfg_gie | input | 1 | Global enable value loaded by `cfg_wr` |
| cfg_en | input | 4 | Per-source enable values loaded by `cfg_wr` |
| flag_clr | input | 4 | Software clear mask, one bit per flag |
| call_ack | input | 1 | Core acknowledges the outstanding call |
| call_req | output | 1 | One-cycle call request |
| call_vec | output | 8 | Vector address, valid while `call_req` is high |
| wake | output | 1 | High while any flag is pending |
| flags | output | 4 | Current request flags |
| gie | output | 1 | Current global enable |

## Verification
Three collisions can happen in a single cycle. A hardware set event can meet a software clear or an acknowledge on the same flag. Several sources can set their flags before one strobe and compete at it. A configuration write can meet an acknowledge that clears the global enable. The bench drives each of these collisions on purpose, with pulses placed in the same cycle. A behavioural reference model then predicts the result every cycle, and the bench compares `flags`, `gie`, `wake`, `call_req` and `call_vec` against the model after each clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned SRC_CNT = 4;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_TMR0 = 2'd1,
    SRC_TMR1 = 2'd2,
    SRC_ADC  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] sel_i,
  output logic       evt_o
);
  logic prev_q, vld_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= pin_i;
      vld_q  <= 1'b1;
    end
  end

  always_comb begin
    rise = vld_q & pin_i & ~prev_q;
    fall = vld_q & ~pin_i & prev_q;
    unique case (edge_e'(sel_i))
      EDGE_RISE: evt_o = rise;
      EDGE_FALL: evt_o = fall;
      EDGE_BOTH: evt_o = rise | fall;
      default:   evt_o = 1'b0;
    endcase
  end

  AST_EDGE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == EDGE_OFF) |-> !evt_o); // R9
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned     N       = 4,
  parameter logic [N-1:0]    PRESENT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    if (PRESENT[i]) begin : g_live
      logic flag_q, flag_d;
      always_comb begin
        flag_d = flag_q;
        if (clr_i[i]) flag_d = 1'b0;
        if (set_i[i]) flag_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
      end
      assign flags_o[i] = flag_q;
    end else begin : g_absent
      assign flags_o[i] = 1'b0;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags_o) & ~$past(clr_i)) & ~flags_o) == '0)); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(set_i) & PRESENT) & ~flags_o) == '0)); // R7
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned  N        = 4,
  parameter logic [N-1:0] PRESENT  = '1,
  parameter int unsigned  VEC_W    = 8,
  parameter int unsigned  VEC_STEP = 4,
  localparam int unsigned IDX_W    = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [VEC_W-1:0] vec_o
);
  function automatic logic [VEC_W-1:0] vec_of(input int unsigned idx);
    int unsigned slot;
    slot = 1;
    for (int unsigned j = 0; j < N; j++)
      if (j < idx && PRESENT[j]) slot++;
    return VEC_W'(slot * VEC_STEP);
  endfunction

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        vec_o = vec_of(i);
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 2,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned VEC_STEP   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_stb,
  input  logic             ext_pin,
  input  logic [1:0]       edge_sel,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  input  logic             adc_done,
  input  logic             stack_full,
  input  logic             cfg_wr,
  input  logic             cfg_gie,
  input  logic [3:0]       cfg_en,
  input  logic [3:0]       flag_clr,
  input  logic             call_ack,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec,
  output logic             wake,
  output logic [3:0]       flags,
  output logic             gie
);
  localparam int unsigned  N       = SRC_CNT;
  localparam int unsigned  IDX_W   = $clog2(N);
  localparam logic [N-1:0] PRESENT = (NUM_TIMERS > 1) ? 4'b1111 : 4'b1011;

  ctl_state_e       state_q, state_d;
  logic             call_q, call_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic [IDX_W-1:0] src_q, src_d;
  logic             gie_q, gie_d;
  logic [N-1:0]     en_q, en_d;

  logic             ext_evt;
  logic [N-1:0]     set_vec, clr_vec, flag_vec, elig;
  logic             arb_any, take, ack_take;
  logic [IDX_W-1:0] arb_idx;
  logic [VEC_W-1:0] arb_vec;

  irq_edge_detect u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (ext_pin),
    .sel_i (edge_sel),
    .evt_o (ext_evt)
  );

  assign set_vec  = {adc_done, tmr1_ovf, tmr0_ovf, ext_evt};
  assign ack_take = (state_q == ST_WAIT) && call_ack;
  assign clr_vec  = flag_clr | (ack_take ? (N'(1) << src_q) : '0);

  irq_flag_bank #(.N(N), .PRESENT(PRESENT)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flag_vec)
  );

  assign elig = flag_vec & en_q & {N{gie_q & ~stack_full}};

  irq_arbiter #(.N(N), .PRESENT(PRESENT), .VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) u_arb (
    .req_i (elig),
    .any_o (arb_any),
    .idx_o (arb_idx),
    .vec_o (arb_vec)
  );

  assign take = (state_q == ST_IDLE) && phase_stb && arb_any;

  always_comb begin
    state_d = state_q;
    call_d  = take;
    vec_d   = vec_q;
    src_d   = src_q;
    en_d    = en_q;
    gie_d   = gie_q;
    if (cfg_wr) begin
      en_d  = cfg_en;
      gie_d = cfg_gie;
    end
    if (take) begin
      state_d = ST_WAIT;
      vec_d   = arb_vec;
      src_d   = arb_idx;
    end
    if (ack_take) begin
      state_d = ST_IDLE;
      gie_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      call_q  <= 1'b0;
      vec_q   <= '0;
      src_q   <= '0;
      en_q    <= '0;
      gie_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      call_q  <= call_d;
      vec_q   <= vec_d;
      src_q   <= src_d;
      en_q    <= en_d;
      gie_q   <= gie_d;
    end
  end

  assign call_req = call_q;
  assign call_vec = vec_q;
  assign flags    = flag_vec;
  assign gie      = gie_q;
  assign wake     = |flag_vec;

  AST_CALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req); // R10
  AST_NO_REEVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !call_ack) |=> !call_req); // R10
  AST_CALL_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(call_req) |-> $past(phase_stb)); // R4
  AST_CALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(gie_q && !stack_full)); // R3
  AST_ACK_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> !gie); // R5
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (call_vec[1:0] == 2'b00 && call_vec != '0)); // R2
endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic phase_stb, ext_pin, tmr0_ovf, tmr1_ovf, adc_done, stack_full;
  logic cfg_wr, cfg_gie, call_ack;
  logic [1:0] edge_sel;
  logic [3:0] cfg_en, flag_clr;
  logic call_req, wake, gie;
  logic [7:0] call_vec;
  logic [3:0] flags;
  logic call_req1, wake1, gie1;
  logic [7:0] call_vec1;
  logic [3:0] flags1;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .phase_stb(phase_stb), .ext_pin(ext_pin),
    .edge_sel(edge_sel), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
    .adc_done(adc_done), .stack_full(stack_full), .cfg_wr(cfg_wr),
    .cfg_gie(cfg_gie), .cfg_en(cfg_en), .flag_clr(flag_clr),
    .call_ack(call_ack), .call_req(call_req), .call_vec(call_vec),
    .wake(wake), .flags(flags), .gie(gie));

  irq_vector_ctrl #(.NUM_TIMERS(1)) i_irq_vector_ctrl_one (
    .clk(clk), .rst_n(rst_n), .phase_stb(phase_stb), .ext_pin(ext_pin),
    .edge_sel(edge_sel), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
    .adc_done(adc_done), .stack_full(stack_full), .cfg_wr(cfg_wr),
    .cfg_gie(cfg_gie), .cfg_en(cfg_en), .flag_clr(flag_clr),
    .call_ack(call_ack), .call_req(call_req1), .call_vec(call_vec1),
    .wake(wake1), .flags(flags1), .gie(gie1));

  // Behavioural reference model of the two-timer build
  bit [3:0] m_flags, m_en;
  bit m_gie, m_wait, m_call, m_prev, m_vld;
  int m_src, m_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = 0; m_en = 0; m_gie = 0; m_wait = 0; m_call = 0;
      m_prev = 0; m_vld = 0; m_src = 0; m_vec = 0;
    end else begin
      bit ev;
      bit [3:0] setb, clrb;
      int win;
      ev = 0;
      if (m_vld) begin
        if (edge_sel == 2'b01 && ext_pin && !m_prev) ev = 1;
        if (edge_sel == 2'b10 && !ext_pin && m_prev) ev = 1;
        if (edge_sel == 2'b11 && ext_pin != m_prev) ev = 1;
      end
      setb = {adc_done, tmr1_ovf, tmr0_ovf, ev};
      clrb = flag_clr;
      win = -1;
      if (!m_wait && phase_stb && m_gie && !stack_full)
        for (int i = 3; i >= 0; i--) if (m_flags[i] && m_en[i]) win = i;
      m_call = (win >= 0);
      if (m_wait && call_ack) begin
        clrb[m_src] = 1'b1;
        m_wait = 0;
        m_gie = 0;
      end else if (cfg_wr) begin
        m_gie = cfg_gie;
      end
      if (cfg_wr) m_en = cfg_en;
      if (win >= 0) begin
        m_wait = 1; m_src = win; m_vec = 4 * (win + 1);
      end
      m_flags = (m_flags & ~clrb) | setb;
      m_prev = ext_pin; m_vld = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Compare with the model after every clock
  always @(negedge clk) if (rst_n && !done) begin
    chk("R6 flags vs model", flags, m_flags);
    chk("R5 gie vs model", gie, m_gie);
    chk("R8 wake vs model", wake, |m_flags);
    chk("R10 call_req vs model", call_req, m_call);
    if (m_call) chk("R2 call_vec vs model", call_vec, m_vec);
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic idle();
    phase_stb = 0; tmr0_ovf = 0; tmr1_ovf = 0; adc_done = 0;
    cfg_wr = 0; flag_clr = 0; call_ack = 0;
  endtask

  task automatic cfg(input bit g, input bit [3:0] e);
    cfg_wr = 1; cfg_gie = g; cfg_en = e; cyc(); idle();
  endtask

  // strobe for one cycle; sample call_req on the next negedge
  task automatic strobe(output bit got, output int v);
    phase_stb = 1; @(negedge clk);
    got = call_req; v = call_vec; #1; idle();
  endtask

  task automatic ack();
    call_ack = 1; cyc(); idle();
  endtask

  initial begin
    #(200000 * 20);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit got;
    int v;
    rst_n = 0; idle(); ext_pin = 0; edge_sel = 2'b00; stack_full = 0;
    cfg_gie = 0; cfg_en = 0;
    cyc(3);
    chk("R12 flags at reset", flags, 0);
    chk("R12 gie at reset", gie, 0);
    chk("R12 call_req at reset", call_req, 0);
    rst_n = 1; cyc(2);

    // R1: timer 1 and converter pending together, timer 1 wins
    cfg(1, 4'hF);
    tmr1_ovf = 1; adc_done = 1; cyc(); idle();
    strobe(got, v);
    chk("R1 call on strobe", got, 1); chk("R1 timer1 over adc", v, 8'h0C);
    cyc(3);
    chk("R10 no re-eval before ack", call_req, 0);
    ack(); cyc();
    chk("R5 flag cleared on ack", flags, 4'b1000);
    chk("R5 gie cleared on ack", gie, 0);
    strobe(got, v); chk("R3 blocked with gie off", got, 0);
    cfg(1, 4'hF);
    strobe(got, v); chk("R2 adc vector", v, 8'h10); ack(); cyc();

    // R9 rising edge + R1 external over timer 0
    edge_sel = 2'b01; cfg(1, 4'hF);
    ext_pin = 1; tmr0_ovf = 1; cyc(); idle();
    chk("R9 rising edge sets flag", flags[0], 1);
    strobe(got, v); chk("R1 external first", v, 8'h04); ack(); cyc();
    cfg(1, 4'hF); strobe(got, v); chk("R2 timer0 vector", v, 8'h08); ack(); cyc();

    // R9 falling and off
    edge_sel = 2'b10; ext_pin = 0; cyc(); chk("R9 falling edge", flags[0], 1);
    flag_clr = 4'b0001; cyc(); idle();
    edge_sel = 2'b00; ext_pin = 1; cyc(); ext_pin = 0; cyc();
    chk("R9 off ignores pin", flags[0], 0);
    edge_sel = 2'b11; ext_pin = 1; cyc(); flag_clr = 1; cyc(); idle();
    ext_pin = 0; cyc(); chk("R9 both edges falling", flags[0], 1);
    flag_clr = 1; cyc(); idle();

    // R3 stack full blocks, R4 no strobe no call
    cfg(1, 4'hF); tmr0_ovf = 1; cyc(); idle();
    cyc(4); chk("R4 no call without strobe", call_req, 0);
    stack_full = 1; strobe(got, v); chk("R3 stack full blocks", got, 0);
    stack_full = 0; strobe(got, v); chk("R4 taken at later strobe", v, 8'h08);
    ack(); cyc();

    // R6 sticky with enable off, software clear
    cfg(1, 4'b0000); adc_done = 1; cyc(); idle(); cyc(3);
    chk("R6 flag sticky enable off", flags[3], 1);
    chk("R8 wake while pending", wake, 1);
    strobe(got, v); chk("R3 enable off blocks", got, 0);
    flag_clr = 4'b1000; cyc(); idle();
    chk("R6 software clear", flags, 0);
    chk("R8 wake low when idle", wake, 0);

    // R7 hardware set wins over software clear and over ack clear
    tmr1_ovf = 1; flag_clr = 4'b0100; cyc(); idle();
    chk("R7 set beats sw clear", flags[2], 1);
    cfg(1, 4'b0100); strobe(got, v); chk("R7 call for timer1", v, 8'h0C);
    call_ack = 1; tmr1_ovf = 1; cfg_wr = 1; cfg_gie = 1; cfg_en = 4'hF; cyc(); idle();
    chk("R7 set beats ack clear", flags[2], 1);
    chk("R5 ack beats cfg write", gie, 0);

    // R11 single-timer build
    flag_clr = 4'hF; cyc(); idle(); cyc();
    cfg(1, 4'hF); tmr1_ovf = 1; adc_done = 1; cyc(); idle();
    chk("R11 timer1 absent", flags1[2], 0);
    chk("R11 wake from adc", wake1, 1);
    phase_stb = 1; @(negedge clk);
    chk("R11 adc vector moved", call_vec1, 8'h0C);
    chk("R11 call raised", call_req1, 1);
    #1; idle(); ack(); cyc(3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule